// File: doc/BRIEF.md
# Multi-Channel Hit Data Packer

This block runs once all per-channel hit finders have finished. It gathers each channel's stored hits into one shared output memory. Each channel keeps up to four hits. A hit is a leading-edge time plus a pulse width, and each channel holds them in two small memories. Those memories sit outside this block: their read data arrives on input ports one clock after the shared read address is presented.

The controller works in three steps. It accepts an acquisition request, waits for the finders to report completion, and then runs a single sweep counter. The counter's low field is the read address sent to every channel at once. Its middle field picks one channel within a group of four, and its top field picks one of the groups. Writes are gated against each channel's hit count, so only real hits land in the output memory. Hits are packed two per 32-bit word.

At the start of the sweep the per-channel hit counts are captured. They are written once, together with a board identifier, to a separate count memory. The number of 32-bit words to read out is reported as well. A done flag marks the end of the transfer.

Top module: `hit_packer`

## Requirements
- R1: After reset, `run_start`, `hit_we`, `cnt_we`, `done`, `ch_rd_addr`, `total_words` and `cnt_wdata` are all zero.
- R2: `acq_req` is accepted only while no readout is in progress. Acceptance gives a one-cycle `run_start` pulse in the next cycle. A request made while a readout is in progress produces no pulse. `stop` is honoured only after an accepted request and before the sweep starts; at any other time it has no effect.
- R3: The cycle after `stop` is sampled, a sweep counter starts at 0 and rises by one per cycle up to 191 (4 hits × 48 channels). `ch_rd_addr` equals counter bits [1:0], so it is `p % 4` in sweep cycle p (p = 0..191) and 0 outside the sweep.
- R4: Counter value c addresses channel c/4 (bits [3:2] pick the channel within a group of four, bits [7:4] pick one of 12 groups) at hit slot c%4. Its entry is presented on the write port exactly 3 cycles after c is on the counter.
- R5: The entry for slot a of channel n is written (`hit_we`=1) only when a+1 ≤ that channel's hit count. `ch_count` is 3 bits per channel, with channel n at bits [3n+2:3n].
- R6: The 16-bit entry index starts at 0 for every readout and advances only on a write. `hit_addr` is the index divided by two.
- R7: An entry is {width[7:0], leading edge[7:0]}, with the edge in the low byte. An entry with an even index is written to bits [15:0] with `hit_be`=2'b11 and zero in bits [31:16]. An entry with an odd index is written to bits [31:16] with `hit_be`=2'b10.
- R8: Hit counts and `board_id` are registered when `stop` is accepted. `cnt_we` pulses for one cycle in sweep cycle 1 with `cnt_wdata` = {board_id, counts}. `cnt_wdata` returns to zero once `done` rises.
- R9: From sweep cycle 1 onward, `total_words` shows the sum of all channel hit counts shifted right by one, as a 7-bit value.
- R10: `done` rises in sweep cycle 195 and stays high until the next accepted `acq_req` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_req | input | 1 | Acquisition request |
| stop | input | 1 | All hit finders finished |
| board_id | input | 16 | Board identification written with the counts |
| ch_count | input | 144 | Per-channel hit count, 3 bits each |
| ch_lead | input | 384 | Per-channel leading-edge read data, 8 bits each |
| ch_width | input | 384 | Per-channel width read data, 8 bits each |
| ch_rd_addr | output | 2 | Shared hit-slot read address to all channels |
| run_start | output | 1 | One-cycle pulse after an accepted request |
| hit_we | output | 1 | Hit memory write enable |
| hit_addr | output | 7 | Hit memory 32-bit word address |
| hit_be | output | 2 | Half-word enables (bit 1 upper, bit 0 lower) |
| hit_wdata | output | 32 | Hit memory write data |
| cnt_we | output | 1 | Count memory write enable |
| cnt_wdata | output | 160 | {board_id, per-channel counts} |
| total_words | output | 7 | Number of 32-bit words to read |
| done | output | 1 | Transfer finished |

## Verification
Timing is counted from the clock edge that samples `stop`, which is sweep cycle 0. The count write is due in cycle 1. The entry for counter value c is due in cycle c+3, the read address follows the counter in the same cycle, and `done` is due in cycle 195. The bench models each channel memory as a register on `ch_rd_addr`. It then compares every output in every cycle from 0 to 199 against a table it builds from the count pattern, sampling on the falling edge. Ignored requests and ignored stops are checked by the absence of `run_start`, of a repeated `cnt_we`, or of any change to the write stream.

// File: rtl/hp_pkg.sv
package hp_pkg;

    localparam int HP_EDGE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SWEEP,
        ST_DRAIN
    } hp_state_e;

    typedef struct packed {
        logic [HP_EDGE_W-1:0] width;
        logic [HP_EDGE_W-1:0] lead;
    } hp_entry_t;

    // place one 16-bit entry in its half of a 32-bit word; the lower half clears the upper
    function automatic logic [2*$bits(hp_entry_t)-1:0] hp_place(hp_entry_t e, logic upper);
        return upper ? {e, {$bits(hp_entry_t){1'b0}}} : {{$bits(hp_entry_t){1'b0}}, e};
    endfunction

endpackage

// File: rtl/hp_sweep_ctrl.sv
module hp_sweep_ctrl
    import hp_pkg::*;
#(
    parameter int SW   = 8,
    parameter int LAST = 191,
    parameter int DLY  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    acq_req,
    input  logic                    stop,
    output logic                    run_start,
    output logic                    stop_ok,
    output logic [SW-1:0]           cnt,
    output logic [DLY-1:0]          vld_d,
    output logic [DLY-1:0][SW-1:0]  pos_d,
    output logic                    finish,
    output logic                    done
);
    hp_state_e state;

    always_comb begin
        stop_ok = (state == ST_WAIT) && stop;
        finish  = vld_d[DLY-1] && (pos_d[DLY-1] == SW'(LAST));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            run_start <= 1'b0;
            done      <= 1'b0;
            vld_d     <= '0;
            pos_d     <= '0;
        end else begin
            run_start <= 1'b0;
            case (state)
                ST_IDLE: if (acq_req) begin
                    state     <= ST_WAIT;
                    run_start <= 1'b1;
                    done      <= 1'b0;
                end
                ST_WAIT: if (stop) state <= ST_SWEEP;
                ST_SWEEP: begin
                    if (cnt == SW'(LAST)) begin
                        cnt   <= '0;
                        state <= ST_DRAIN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DRAIN: if (finish) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
            vld_d[0] <= (state == ST_SWEEP);
            pos_d[0] <= cnt;
            for (int i = 1; i < DLY; i++) begin
                vld_d[i] <= vld_d[i-1];
                pos_d[i] <= pos_d[i-1];
            end
        end
    end
endmodule

// File: rtl/hp_select.sv
module hp_select
    import hp_pkg::*;
#(
    parameter int NCH = 48,
    parameter int GRP = 4,
    parameter int GSW = 2,
    parameter int TSW = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NCH*HP_EDGE_W-1:0]  ch_lead,
    input  logic [NCH*HP_EDGE_W-1:0]  ch_width,
    input  logic [GSW-1:0]            sel_in_grp,
    input  logic [TSW-1:0]            sel_grp,
    output hp_entry_t                 entry_q
);
    localparam int NGRP = NCH / GRP;

    hp_entry_t grp_q [NGRP];
    hp_entry_t entry_n;

    // first level: one channel out of each group of GRP
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (rst) begin
                grp_q[g] <= '0;
            end else begin
                grp_q[g].lead  <= ch_lead [(g*GRP + int'(sel_in_grp))*HP_EDGE_W +: HP_EDGE_W];
                grp_q[g].width <= ch_width[(g*GRP + int'(sel_in_grp))*HP_EDGE_W +: HP_EDGE_W];
            end
        end
    end

    // second level: one group out of NGRP
    always_comb begin
        entry_n = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (sel_grp == TSW'(g)) entry_n = grp_q[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) entry_q <= '0;
        else     entry_q <= entry_n;
    end
endmodule

// File: rtl/hp_count_snap.sv
module hp_count_snap #(
    parameter int NCH  = 48,
    parameter int CW   = 3,
    parameter int IDW  = 16,
    parameter int SUMW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take,
    input  logic                 clear,
    input  logic [NCH*CW-1:0]    ch_count,
    input  logic [IDW-1:0]       board_id,
    output logic [NCH*CW-1:0]    snap,
    output logic                 cnt_we,
    output logic [IDW+NCH*CW-1:0] cnt_wdata,
    output logic [SUMW-2:0]      total_words
);
    logic [IDW-1:0]  id_q;
    logic            take_q;
    logic [SUMW-1:0] sum;

    always_comb begin
        sum = '0;
        for (int n = 0; n < NCH; n++) sum = sum + SUMW'(snap[n*CW +: CW]);
        cnt_wdata = {id_q, snap};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap        <= '0;
            id_q        <= '0;
            take_q      <= 1'b0;
            cnt_we      <= 1'b0;
            total_words <= '0;
        end else begin
            take_q <= take;
            cnt_we <= take_q;
            if (take_q) total_words <= sum[SUMW-1:1];
            if (clear) begin
                snap <= '0;
                id_q <= '0;
            end else if (take) begin
                snap <= ch_count;
                id_q <= board_id;
            end
        end
    end
endmodule

// File: rtl/hp_writer.sv
module hp_writer
    import hp_pkg::*;
#(
    parameter int NCH = 48,
    parameter int CW  = 3,
    parameter int AW  = 2,
    parameter int SW  = 8,
    parameter int EAW = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          vld,
    input  logic [SW-1:0]                 pos,
    input  hp_entry_t                     entry,
    input  logic [NCH*CW-1:0]             snap,
    input  logic                          finish,
    output logic                          hit_we,
    output logic [EAW-2:0]                hit_addr,
    output logic [1:0]                    hit_be,
    output logic [2*$bits(hp_entry_t)-1:0] hit_wdata
);
    localparam int CHW = SW - AW;

    logic [EAW-1:0] ent;
    logic [CW-1:0]  cnt_sel;

    always_comb begin
        cnt_sel = '0;
        for (int n = 0; n < NCH; n++) begin
            if (pos[SW-1:AW] == CHW'(n)) cnt_sel = snap[n*CW +: CW];
        end
        hit_we    = vld && ((CW+1)'(pos[AW-1:0]) + 1'b1 <= (CW+1)'(cnt_sel));
        hit_addr  = ent[EAW-1:1];
        hit_be    = ent[0] ? 2'b10 : 2'b11;
        hit_wdata = hp_place(entry, ent[0]);
    end

    always_ff @(posedge clk) begin
        if (rst || finish) ent <= '0;
        else if (hit_we)   ent <= ent + 1'b1;
    end
endmodule

// File: rtl/hit_packer.sv
module hit_packer
    import hp_pkg::*;
#(
    parameter int NCH  = 48,
    parameter int HITS = 4,
    parameter int GRP  = 4,
    parameter int CW   = 3,
    parameter int IDW  = 16,
    parameter int DLY  = 3,
    localparam int AW   = $clog2(HITS),
    localparam int GSW  = $clog2(GRP),
    localparam int TSW  = $clog2(NCH / GRP),
    localparam int SW   = AW + GSW + TSW,
    localparam int EAW  = $clog2(NCH * HITS),
    localparam int SUMW = $clog2(NCH * HITS + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          acq_req,
    input  logic                          stop,
    input  logic [IDW-1:0]                board_id,
    input  logic [NCH*CW-1:0]             ch_count,
    input  logic [NCH*HP_EDGE_W-1:0]      ch_lead,
    input  logic [NCH*HP_EDGE_W-1:0]      ch_width,
    output logic [AW-1:0]                 ch_rd_addr,
    output logic                          run_start,
    output logic                          hit_we,
    output logic [EAW-2:0]                hit_addr,
    output logic [1:0]                    hit_be,
    output logic [4*HP_EDGE_W-1:0]        hit_wdata,
    output logic                          cnt_we,
    output logic [IDW+NCH*CW-1:0]         cnt_wdata,
    output logic [SUMW-2:0]               total_words,
    output logic                          done
);
    logic                   stop_ok, finish;
    logic [SW-1:0]          cnt;
    logic [DLY-1:0]         vld_d;
    logic [DLY-1:0][SW-1:0] pos_d;
    logic [NCH*CW-1:0]      snap;
    hp_entry_t              entry_q;

    assign ch_rd_addr = cnt[AW-1:0];

    hp_sweep_ctrl #(.SW(SW), .LAST(NCH*HITS-1), .DLY(DLY)) u_ctrl (
        .clk, .rst, .acq_req, .stop,
        .run_start, .stop_ok, .cnt, .vld_d, .pos_d, .finish, .done
    );

    // memory data for pos_d[0] arrives with it; group select then top select
    hp_select #(.NCH(NCH), .GRP(GRP), .GSW(GSW), .TSW(TSW)) u_sel (
        .clk, .rst, .ch_lead, .ch_width,
        .sel_in_grp (pos_d[0][AW +: GSW]),
        .sel_grp    (pos_d[1][SW-1 -: TSW]),
        .entry_q
    );

    hp_count_snap #(.NCH(NCH), .CW(CW), .IDW(IDW), .SUMW(SUMW)) u_snap (
        .clk, .rst, .take(stop_ok), .clear(finish), .ch_count, .board_id,
        .snap, .cnt_we, .cnt_wdata, .total_words
    );

    hp_writer #(.NCH(NCH), .CW(CW), .AW(AW), .SW(SW), .EAW(EAW)) u_wr (
        .clk, .rst, .vld(vld_d[DLY-1]), .pos(pos_d[DLY-1]), .entry(entry_q),
        .snap, .finish, .hit_we, .hit_addr, .hit_be, .hit_wdata
    );
endmodule

// File: rtl/hit_packer_chk.sv
module hit_packer_chk (
    input logic        clk,
    input logic        rst,
    input logic        run_start,
    input logic        cnt_we,
    input logic        hit_we,
    input logic [1:0]  hit_be,
    input logic [31:0] hit_wdata,
    input logic        done
);
    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        run_start |=> !run_start);

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        run_start |-> !done);

    assert_count_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> !cnt_we);

    assert_upper_lane_R7: assert property (@(posedge clk) disable iff (rst)
        hit_we |-> hit_be[1]);

    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (hit_we && hit_be[0]) |-> (hit_wdata[31:16] == 16'h0));

    assert_no_write_done_R4: assert property (@(posedge clk) disable iff (rst)
        hit_we |-> !done);

    assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(done) |-> run_start);
endmodule

bind hit_packer hit_packer_chk u_chk (
    .clk(clk), .rst(rst), .run_start(run_start), .cnt_we(cnt_we),
    .hit_we(hit_we), .hit_be(hit_be), .hit_wdata(hit_wdata), .done(done)
);

// File: tb/hit_packer_tb.sv
`timescale 1ns/1ps
module hit_packer_tb;
    localparam int NCH = 48;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         acq_req = 1'b0;
    logic         stop = 1'b0;
    logic [15:0]  board_id = 16'h0;
    logic [143:0] ch_count = '0;
    logic [383:0] ch_lead, ch_width;
    logic [1:0]   ch_rd_addr;
    logic         run_start, hit_we, cnt_we, done;
    logic [6:0]   hit_addr;
    logic [1:0]   hit_be;
    logic [31:0]  hit_wdata;
    logic [159:0] cnt_wdata;
    logic [6:0]   total_words;
    int           seed = 0;
    int           total = 0;
    int           bad = 0;

    always #4 clk = ~clk;

    hit_packer u_dut (
        .clk, .rst, .acq_req, .stop, .board_id, .ch_count, .ch_lead, .ch_width,
        .ch_rd_addr, .run_start, .hit_we, .hit_addr, .hit_be, .hit_wdata,
        .cnt_we, .cnt_wdata, .total_words, .done
    );

    function automatic logic [7:0] lead_of(int ch, int a, int s);
        return 8'((ch*37 + a*11 + s) & 255);
    endfunction
    function automatic logic [7:0] width_of(int ch, int a, int s);
        return 8'((ch*13 + a*29 + s*3 + 1) & 255);
    endfunction

    // channel memories: registered read on the shared address
    always_ff @(posedge clk) begin
        for (int ch = 0; ch < NCH; ch++) begin
            ch_lead [ch*8 +: 8] <= lead_of(ch, int'(ch_rd_addr), seed);
            ch_width[ch*8 +: 8] <= width_of(ch, int'(ch_rd_addr), seed);
        end
    end

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic start_acq();
        @(negedge clk) acq_req = 1'b1;
        @(negedge clk) acq_req = 1'b0;
        check(run_start == 1'b1, "R2 start pulse", 64'(run_start), 64'd1);
        check(done == 1'b0, "R10 done cleared on accept", 64'(done), 64'd0);
        @(negedge clk) acq_req = 1'b1;   // request while busy: ignored
        check(run_start == 1'b0, "R2 pulse length", 64'(run_start), 64'd0);
        @(negedge clk) acq_req = 1'b0;
        check(run_start == 1'b0, "R2 busy request ignored", 64'(run_start), 64'd0);
    endtask

    task automatic run_one(input int mode, input int s, input logic stop_mid);
        int cnt_of [NCH];
        int sum = 0;
        int k = 0;
        seed = s;
        board_id = 16'(16'hB000 + s);
        for (int ch = 0; ch < NCH; ch++) begin
            case (mode)
                0: cnt_of[ch] = 0;
                1: cnt_of[ch] = 4;
                2: cnt_of[ch] = ch % 5;
                default: cnt_of[ch] = (ch*7 + 3) % 5;
            endcase
            ch_count[ch*3 +: 3] = 3'(cnt_of[ch]);
            sum += cnt_of[ch];
        end
        start_acq();
        @(negedge clk) stop = 1'b1;
        @(negedge clk) stop = 1'b0;
        for (int p = 0; p < 200; p++) begin
            if (stop_mid && p == 60) stop = 1'b1;
            if (stop_mid && p == 61) stop = 1'b0;
            check(cnt_we == (p == 1), "R8 count write timing", 64'(cnt_we), 64'(p == 1));
            if (p == 1) begin
                check(cnt_wdata[159:144] == board_id, "R8 board id", 64'(cnt_wdata[159:144]), 64'(board_id));
                check(cnt_wdata[143:0] == ch_count, "R8 counts", 64'(cnt_wdata[63:0]), 64'(ch_count[63:0]));
            end
            if (p >= 1)
                check(total_words == 7'(sum/2), "R9 word total", 64'(total_words), 64'(sum/2));
            check(ch_rd_addr == (p < 192 ? 2'(p % 4) : 2'd0), "R3 read address", 64'(ch_rd_addr), 64'(p < 192 ? p % 4 : 0));
            begin
                int c = p - 3;
                logic exp_we = (c >= 0 && c < 192) && ((c % 4) < cnt_of[(c >= 0 ? c : 0) / 4]);
                check(hit_we == exp_we, "R5 write gate", 64'(hit_we), 64'(exp_we));
                if (exp_we && hit_we) begin
                    logic [15:0] e = {width_of(c/4, c%4, s), lead_of(c/4, c%4, s)};
                    logic [31:0] w = (k % 2 == 1) ? {e, 16'h0} : {16'h0, e};
                    check(hit_addr == 7'(k/2), "R6 entry address", 64'(hit_addr), 64'(k/2));
                    check(hit_be == ((k % 2 == 1) ? 2'b10 : 2'b11), "R7 half enable", 64'(hit_be), 64'((k % 2 == 1) ? 2 : 3));
                    check(hit_wdata == w, "R4 entry data", 64'(hit_wdata), 64'(w));
                end
                if (exp_we) k++;
            end
            check(done == (p >= 195), "R10 done timing", 64'(done), 64'(p >= 195));
            if (p == 196)
                check(cnt_wdata == '0, "R8 count bus cleared", 64'(cnt_wdata[63:0]), 64'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!run_start && !hit_we && !cnt_we && !done, "R1 reset controls", 64'({run_start, hit_we, cnt_we, done}), 64'd0);
        check(ch_rd_addr == 2'd0 && total_words == 7'd0, "R1 reset address/total", 64'({ch_rd_addr, total_words}), 64'd0);
        check(cnt_wdata == '0, "R1 reset count bus", 64'(cnt_wdata[63:0]), 64'd0);
        // stop while idle: ignored
        @(negedge clk) stop = 1'b1;
        @(negedge clk) stop = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check(!cnt_we && ch_rd_addr == 2'd0, "R2 idle stop ignored", 64'({cnt_we, ch_rd_addr}), 64'd0);
            @(negedge clk);
        end
        run_one(0, 5, 1'b0);
        run_one(1, 9, 1'b0);
        run_one(2, 17, 1'b1);
        run_one(3, 42, 1'b0);
        check(done == 1'b1, "R10 done held", 64'(done), 64'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule